// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is the countdown timer of an interrupt controller. Software programs it through a small register port: a timer entry that holds the vector, a mask bit and a periodic-mode bit, an initial-count register, a divide-configuration register, and a read-only current-count register. A clock-enable `tick` input supplies the time base. A prescaler divides it by a power of two that is decoded from the divide field. Each divided tick lowers the current count by one.

When the count reaches zero, the timer raises a pending request for its vector, unless the entry is masked or the controller is software-disabled. In periodic mode the count then reloads from the initial count. In one-shot mode the count stays at zero. An expiry that arrives while the request is still pending is counted rather than lost. Each acknowledge of the pending vector consumes one counted expiry and keeps the request raised, until the count is used up.

Top module: `lt_timer`

## Requirements
- R1: The divide ratio is 2^k, where k = ({div[3], div[1], div[0]} + 1) mod 8. Code 0x0 divides by 2, 0x3 by 16, 0x8 by 32, 0xA by 128 and 0xB by 1. The divide register (select 3) keeps bits 3:0 and reads zero above them.
- R2: A write to the initial count (select 1) loads the same value into the current count and restarts the prescaler. The write wins over a divided tick in the same cycle. The current count never exceeds the initial count.
- R3: On expiry in periodic mode (timer-entry bit 17 = 1), the current count reloads from the initial count. In one-shot mode it stays at zero.
- R4: On expiry, `pend_valid` rises one cycle later and `pend_vector` carries timer-entry bits 7:0. Both hold until an acknowledge consumes the request.
- R5: An expiry while timer-entry bit 16 (mask) is 1, or while `sw_enable` is 0, raises no request.
- R6: Only bits 7:0 (vector), 16 (mask) and 17 (periodic) of the timer entry (select 0) are writable. All other bits read as zero.
- R7: After reset the timer entry reads 0x00010000 (masked). The initial count, the current count, the divide register and `pend_valid` are all zero.
- R8: An initial count of zero leaves the timer stopped, with no expiry.
- R9: The current count (select 2) drops by one per divided tick and can be read at any time without disturbing the countdown. Writes to select 2 are ignored.
- R10: An expiry while the request is pending increments an overflow count. An acknowledge of the pending vector with a nonzero overflow count decrements the count and leaves `pend_valid` high. With a zero count, the acknowledge clears `pend_valid`.
- R11: An acknowledge whose vector differs from `pend_vector` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base clock enable |
| sw_enable | input | 1 | Controller software enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 entry, 1 initial, 2 current, 3 divide |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Read select, same encoding as wr_sel |
| rd_data | output | DATA_W | Combinational read data |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_vector | input | 8 | Vector being acknowledged |
| pend_valid | output | 1 | Pending timer request |
| pend_vector | output | 8 | Vector of the pending request |

## Verification
A register write takes effect at the next clock edge. The bench drives every input on the falling edge and samples one falling edge later, so the read-back after a write reflects exactly one edge.

With divide ratio r, the count first drops after r ticking edges following an initial-count write, and the bench samples at r-1 and at r edges to pin that boundary. An expiry raises `pend_valid` at the same edge that the count reaches zero, so the request is checked on the sample where the count first reads zero. Acknowledges are one-cycle pulses, checked on the next sample.

// File: rtl/lt_pkg.sv
package lt_pkg;
    localparam int SHIFT_W = 3;

    typedef enum logic [1:0] {
        SEL_ENTRY = 2'd0,
        SEL_INIT  = 2'd1,
        SEL_CUR   = 2'd2,
        SEL_DIV   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       periodic;
        logic       mask;
        logic [7:0] vector;
    } entry_t;

    // divide field -> power-of-two exponent, wraps 7+1 to 0
    function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] code);
        return {code[3], code[1:0]} + 3'd1;
    endfunction
endpackage

// File: rtl/lt_prescale.sv
module lt_prescale #(
    parameter int SHIFT_W = 3,
    localparam int PRESC_W = (1 << SHIFT_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               strobe
);
    localparam logic [PRESC_W-1:0] ONE = PRESC_W'(1);

    typedef struct packed {
        logic [PRESC_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [PRESC_W:0]   pow;
    logic [PRESC_W-1:0] limit;

    always_comb begin
        pow    = (PRESC_W + 1)'(1) << shift;
        limit  = pow[PRESC_W-1:0] - ONE;
        strobe = tick && (st_q.cnt == limit);
        st_d   = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = strobe ? '0 : st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lt_countdown.sv
module lt_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             strobe,
    input  logic             periodic,
    output logic [CNT_W-1:0] cur,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cur;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (load) begin
            st_d.cur = load_val;
        end else if (strobe && (st_q.cur != '0)) begin
            if (st_q.cur == ONE) begin
                expire   = 1'b1;
                st_d.cur = periodic ? load_val : '0;
            end else begin
                st_d.cur = st_q.cur - ONE;
            end
        end
    end

    assign cur = st_q.cur;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lt_pending.sv
module lt_pending #(
    parameter int OVF_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic [7:0] fire_vec,
    input  logic       ack_valid,
    input  logic [7:0] ack_vec,
    output logic       pend,
    output logic [7:0] pend_vec
);
    localparam logic [OVF_W-1:0] ONE = OVF_W'(1);

    typedef struct packed {
        logic             pend;
        logic [7:0]       vec;
        logic [OVF_W-1:0] ovf;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // acknowledge first, then fold in a new expiry
        if (ack_valid && st_q.pend && (ack_vec == st_q.vec)) begin
            if (st_q.ovf != '0) st_d.ovf  = st_q.ovf - ONE;
            else                st_d.pend = 1'b0;
        end
        if (fire) begin
            if (st_d.pend) begin
                if (st_d.ovf != '1) st_d.ovf = st_d.ovf + ONE;
            end else begin
                st_d.pend = 1'b1;
                st_d.vec  = fire_vec;
            end
        end
    end

    assign pend     = st_q.pend;
    assign pend_vec = st_q.vec;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lt_timer.sv
module lt_timer
    import lt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int OVF_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              sw_enable,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ack_valid,
    input  logic [7:0]        ack_vector,
    output logic              pend_valid,
    output logic [7:0]        pend_vector
);
    typedef struct packed {
        entry_t           entry;
        logic [3:0]       div;
        logic [CNT_W-1:0] init;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic             init_wr;
    logic             div_wr;
    logic             strobe;
    logic             expire;
    logic             fire;
    logic [CNT_W-1:0] cur_w;
    logic [CNT_W-1:0] init_w;
    logic             ent_mask;
    logic             ent_periodic;

    always_comb begin
        cfg_d   = cfg_q;
        init_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_INIT);
        div_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_DIV);
        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_ENTRY: begin
                    cfg_d.entry.vector   = wr_data[7:0];
                    cfg_d.entry.mask     = wr_data[16];
                    cfg_d.entry.periodic = wr_data[17];
                end
                SEL_INIT: cfg_d.init = wr_data[CNT_W-1:0];
                SEL_DIV:  cfg_d.div  = wr_data[3:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q            <= '0;
            cfg_q.entry.mask <= 1'b1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    lt_prescale #(.SHIFT_W(SHIFT_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (init_wr || div_wr),
        .shift   (div_shift(cfg_q.div)),
        .strobe  (strobe)
    );

    lt_countdown #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (init_wr),
        .load_val (init_wr ? wr_data[CNT_W-1:0] : cfg_q.init),
        .strobe   (strobe),
        .periodic (cfg_q.entry.periodic),
        .cur      (cur_w),
        .expire   (expire)
    );

    assign fire = expire && !cfg_q.entry.mask && sw_enable;

    lt_pending #(.OVF_W(OVF_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .fire_vec  (cfg_q.entry.vector),
        .ack_valid (ack_valid),
        .ack_vec   (ack_vector),
        .pend      (pend_valid),
        .pend_vec  (pend_vector)
    );

    assign init_w       = cfg_q.init;
    assign ent_mask     = cfg_q.entry.mask;
    assign ent_periodic = cfg_q.entry.periodic;

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_ENTRY: rd_data = DATA_W'({cfg_q.entry.periodic, cfg_q.entry.mask,
                                          8'h00, cfg_q.entry.vector});
            SEL_INIT:  rd_data = DATA_W'(cfg_q.init);
            SEL_CUR:   rd_data = DATA_W'(cur_w);
            default:   rd_data = DATA_W'(cfg_q.div);
        endcase
    end
endmodule

// File: rtl/lt_timer_chk.sv
module lt_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_wr,
    input logic             sw_enable,
    input logic             ent_mask,
    input logic             ent_periodic,
    input logic [CNT_W-1:0] cur_w,
    input logic [CNT_W-1:0] init_w,
    input logic             ack_valid,
    input logic [7:0]       ack_vector,
    input logic             pend_valid,
    input logic [7:0]       pend_vector
);
    AST_CUR_LE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        cur_w <= init_w); // R2

    AST_CUR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !init_wr |=> (cur_w == $past(cur_w) || cur_w == $past(cur_w) - 1'b1
                      || cur_w == $past(init_w))); // R9

    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ent_periodic && cur_w == '0 && !init_wr) |=> (cur_w == '0)); // R3

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_valid) |-> $past(!ent_mask && sw_enable)); // R5

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && !(ack_valid && ack_vector == pend_vector))
        |=> (pend_valid && $stable(pend_vector))); // R4

    AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (init_w == '0 && cur_w == '0 && !pend_valid) |=> !pend_valid); // R8
endmodule

bind lt_timer lt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_wr      (init_wr),
    .sw_enable    (sw_enable),
    .ent_mask     (ent_mask),
    .ent_periodic (ent_periodic),
    .cur_w        (cur_w),
    .init_w       (init_w),
    .ack_valid    (ack_valid),
    .ack_vector   (ack_vector),
    .pend_valid   (pend_valid),
    .pend_vector  (pend_vector)
);

// File: tb/sim_lt_timer.sv
module sim_lt_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        sw_enable = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        ack_valid = 1'b0;
    logic [7:0]  ack_vector = '0;
    logic        pend_valid;
    logic [7:0]  pend_vector;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lt_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sw_enable(sw_enable),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .ack_valid(ack_valid), .ack_vector(ack_vector),
        .pend_valid(pend_valid), .pend_vector(pend_vector)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] val);
        rd_sel = sel;
        #1 val = rd_data;
    endtask

    task automatic ack(input logic [7:0] vec);
        ack_valid = 1'b1; ack_vector = vec;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R7 entry", v, 32'h0001_0000);
        rd(2'd1, v); check("R7 init", v, 0);
        rd(2'd2, v); check("R7 cur", v, 0);
        rd(2'd3, v); check("R7 div", v, 0);
        check("R7 pend", {31'd0, pend_valid}, 0);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); check("R6 entry bits", v, 32'h0003_00FF);
        wr(2'd3, 32'hFFFF_FFF7);
        rd(2'd3, v); check("R1 div bits", v, 32'h7);
        wr(2'd0, 32'h0001_0000);
    endtask

    task automatic t_ratio(input logic [3:0] code, input int ratio);
        logic [31:0] v;
        tick = 1'b0;
        wr(2'd3, {28'd0, code});
        wr(2'd1, 32'd10);
        tick = 1'b1;
        if (ratio > 1) begin
            edges(ratio - 1);
            rd(2'd2, v); check($sformatf("R1 code %0h before", code), v, 10);
        end
        edges(1);
        rd(2'd2, v); check($sformatf("R1 code %0h step", code), v, 9);
        tick = 1'b0;
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(2'd3, 32'hB);
        wr(2'd0, 32'h40);
        wr(2'd1, 32'd3);
        tick = 1'b1;
        edges(2);
        rd(2'd2, v); check("R9 count", v, 1);
        check("R4 not yet", {31'd0, pend_valid}, 0);
        edges(1);
        rd(2'd2, v); check("R9 zero", v, 0);
        check("R4 pend", {31'd0, pend_valid}, 1);
        check("R4 vector", {24'd0, pend_vector}, 32'h40);
        edges(3);
        rd(2'd2, v); check("R3 oneshot hold", v, 0);
        tick = 1'b0;
        ack(8'h41);
        check("R11 wrong ack", {31'd0, pend_valid}, 1);
        ack(8'h40);
        check("R10 ack clears", {31'd0, pend_valid}, 0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(2'd0, 32'h0002_0050);
        wr(2'd1, 32'd3);
        tick = 1'b1;
        edges(3);
        rd(2'd2, v); check("R3 reload", v, 3);
        check("R4 pend", {31'd0, pend_valid}, 1);
        check("R4 vector", {24'd0, pend_vector}, 32'h50);
        edges(3);
        tick = 1'b0;
        check("R10 still pend", {31'd0, pend_valid}, 1);
        ack(8'h50);
        check("R10 reassert", {31'd0, pend_valid}, 1);
        ack(8'h50);
        check("R10 drained", {31'd0, pend_valid}, 0);
        wr(2'd1, 32'd0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(2'd0, 32'h0001_0060);
        wr(2'd1, 32'd2);
        tick = 1'b1;
        edges(3);
        tick = 1'b0;
        rd(2'd2, v); check("R5 masked count", v, 0);
        check("R5 masked", {31'd0, pend_valid}, 0);
        sw_enable = 1'b0;
        wr(2'd0, 32'h60);
        wr(2'd1, 32'd2);
        tick = 1'b1;
        edges(3);
        tick = 1'b0;
        check("R5 sw disabled", {31'd0, pend_valid}, 0);
        sw_enable = 1'b1;
    endtask

    task automatic t_zero();
        logic [31:0] v;
        wr(2'd1, 32'd0);
        tick = 1'b1;
        edges(20);
        tick = 1'b0;
        rd(2'd2, v); check("R8 zero cur", v, 0);
        check("R8 no expiry", {31'd0, pend_valid}, 0);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        wr(2'd1, 32'd5);
        tick = 1'b1;
        edges(2);
        rd(2'd2, v); check("R2 counting", v, 3);
        wr(2'd1, 32'd7);
        rd(2'd2, v); check("R2 reload on write", v, 7);
        edges(1);
        rd(2'd2, v); check("R2 restart step", v, 6);
        tick = 1'b0;
        wr(2'd2, 32'h1234);
        rd(2'd2, v); check("R9 cur write ignored", v, 6);
        rd(2'd1, v); check("R9 init untouched", v, 7);
        wr(2'd1, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_fields();
        t_ratio(4'h0, 2);
        t_ratio(4'h3, 16);
        t_ratio(4'h8, 32);
        t_ratio(4'hA, 128);
        t_ratio(4'hB, 1);
        t_oneshot();
        t_periodic();
        t_mask();
        t_zero();
        t_restart();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule